// File: doc/BRIEF.md
# Delta-Sigma ADC Frame Readout Controller

This block drives a delta-sigma converter whose single serial data line carries two things in turn: a fixed-length ready pattern, then the conversion result. From the fast system clock it makes the converter's master clock, a square wave that never stops. The converter needs that clock to run through readout as well, because each conversion runs while the previous result is being read. Each frame lasts exactly `FRAME_CLKS` (384) master-clock periods. The block finds the start of a frame from a rising edge on the data line and checks the ready pattern at two fixed points. It then pulses the serial clock to shift the 24-bit result in, MSB first.

A finished word appears on `sample` as a two's-complement value, with a one-cycle `sample_valid` strobe. If the ready pattern is wrong, the block drops the frame, pulses `sync_err` and goes back to hunting. The master clock keeps running throughout.

The controller has four states. `ST_HUNT` waits for a rising edge on the data line. `ST_MARKER` counts periods 1 to 35 of the ready pattern and checks it. `ST_SHIFT` covers periods 36 to 83, one serial-clock pulse per bit. `ST_TRAIL` covers the extra serial-clock pulse and then the idle periods up to 383. The transitions are:
- *detect*: `ST_HUNT` to `ST_MARKER`.
- *mismatch*: `ST_MARKER` to `ST_HUNT`, which raises `sync_err`.
- *marker done*: `ST_MARKER` to `ST_SHIFT`.
- *bits done*: `ST_SHIFT` to `ST_TRAIL`.
- *frame end*: `ST_TRAIL` to `ST_HUNT`. This arms detection for period 0 of the next frame.

Top module: `adc_frame_reader`

## Requirements
- R1: `adc_clk` is a continuous square wave that is high for `HALF_DIV` system cycles and low for `HALF_DIV` system cycles. It never pauses, whether during readout, after a sync error or while hunting.
- R2: The block samples the data line once per master-clock period, at the end of that period. In hunt, a frame starts with the first period sampled high right after a period sampled low. A line that is already high when reset is released does not start a frame.
- R3: Periods are numbered from 0, the first period sampled high. If the line is high in period 12 or low in period 15, the block does the following: it pulses `sync_err` for one system cycle, produces no `adc_sclk` pulse and no `sample_valid` for that frame, and returns to hunt.
- R4: A frame that passes the check gets exactly 25 `adc_sclk` pulses. For bit b (0 to 23), `adc_sclk` is high in period 36+2b and low in period 37+2b. One extra pulse is high in period 84. `adc_sclk` is low in every other period, and it changes only on a rising edge of `adc_clk`.
- R5: Each data bit is taken at the end of its `adc_sclk`-high period. The first bit taken becomes bit 23 of `sample`, and the last becomes bit 0.
- R6: After the 24th bit, `sample_valid` is high for exactly one system cycle, once per good frame. `sample` then holds that word as a signed two's-complement value until the next strobe.
- R7: Frames that follow one another with no gap are all captured, because period 384 of one frame is recognised as period 0 of the next.
- R8: After a sync error, the next rising edge of the data line starts a new frame, which is checked and captured normally.
- R9: During reset, `adc_clk`, `adc_sclk`, `sample_valid`, `sync_err` and `sample` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_dout | input | 1 | Serial data line from the converter (ready pattern, then data) |
| adc_clk | output | 1 | Converter master clock, 1/(2*HALF_DIV) of `clk` |
| adc_sclk | output | 1 | Serial shift clock, edges aligned to `adc_clk` rising edges |
| sample | output | DATA_BITS | Last captured word, two's complement |
| sample_valid | output | 1 | One-cycle strobe when `sample` updates |
| sync_err | output | 1 | One-cycle strobe when the ready pattern does not match |

## Verification
The bench plays whole frames back to back. Their words exercise the sign bit and the extreme codes: all ones, all zeros, 0x800000, 0x7FFFFF and alternating patterns. These show up a reversed bit order, an off-by-one in the bit sample point, or a lost sign. It also plays a pattern that never goes low, and one that never comes back high, each followed by a good frame. A controller that skips either check would shift in garbage and strobe valid. One that fails to recover would miss the following word. A high line at reset release and seamless frame-to-frame joins test the rising-edge detect: an error there would show as false sync errors or dropped frames. The bench also counts serial-clock pulses per frame and measures every master-clock half period. A gap in the clock, or a stray or missing pulse, is reported.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_MARKER,
        ST_SHIFT,
        ST_TRAIL
    } rd_state_t;

endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic adc_clk,
    output logic period_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          clk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            clk_q <= ~clk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // last system cycle of the low half: one master-clock period ends here
    assign period_tick = (cnt_q == LAST) && !clk_q;
    assign adc_clk     = clk_q;

endmodule

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) ff[gi] <= 1'b1;
                    else        ff[gi] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) ff[gi] <= 1'b1;
                    else        ff[gi] <= ff[gi-1];
                end
            end
        end
    endgenerate

    assign q = ff[STAGES-1];

endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
    import adc_rd_pkg::*;
#(
    parameter int FRAME_CLKS  = 384,
    parameter int MARKER_CLKS = 36,
    parameter int LOW_AT      = 12,
    parameter int HIGH_AT     = 15,
    parameter int DATA_BITS   = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic sclk,
    output logic shift_en,
    output logic last_bit,
    output logic sync_err
);
    localparam int PW        = $clog2(FRAME_CLKS + 1);
    localparam int DATA_END  = MARKER_CLKS + 2 * DATA_BITS;
    localparam int PULSE_END = DATA_END + 2;

    rd_state_t     state_q, state_d;
    logic [PW-1:0] per_q, per_d;
    logic          prev_q, prev_d;
    logic          fail;
    logic          sclk_d;
    logic [PW-1:0] per_nxt;
    logic [PW-1:0] off_end, off_new;

    assign per_nxt = per_q + 1'b1;
    assign off_end = per_q - PW'(MARKER_CLKS);
    assign off_new = per_d - PW'(MARKER_CLKS);

    // next state, evaluated once per master-clock period
    always_comb begin
        state_d = state_q;
        per_d   = per_q;
        prev_d  = prev_q;
        fail    = 1'b0;
        if (tick) begin
            prev_d = din;
            unique case (state_q)
                ST_HUNT: begin
                    if (din && !prev_q) begin
                        state_d = ST_MARKER;
                        per_d   = PW'(1);
                    end
                end
                ST_MARKER: begin
                    per_d = per_nxt;
                    if ((per_q == PW'(LOW_AT) && din) ||
                        (per_q == PW'(HIGH_AT) && !din)) begin
                        fail    = 1'b1;
                        state_d = ST_HUNT;
                        per_d   = '0;
                    end else if (per_q == PW'(MARKER_CLKS - 1)) begin
                        state_d = ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    per_d = per_nxt;
                    if (per_q == PW'(DATA_END - 1)) state_d = ST_TRAIL;
                end
                ST_TRAIL: begin
                    per_d = per_nxt;
                    if (per_q == PW'(FRAME_CLKS - 1)) begin
                        state_d = ST_HUNT;
                        per_d   = '0;
                        prev_d  = 1'b0;
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            per_q   <= '0;
            prev_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            per_q   <= per_d;
            prev_q  <= prev_d;
        end
    end

    // serial clock level for the period that is about to begin
    assign sclk_d = (state_d != ST_HUNT) &&
                    (per_d >= PW'(MARKER_CLKS)) &&
                    (per_d < PW'(PULSE_END)) &&
                    !off_new[0];

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk     <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            if (tick) sclk <= sclk_d;
            sync_err <= fail;
        end
    end

    assign shift_en = tick && (state_q == ST_SHIFT) && !off_end[0];
    assign last_bit = shift_en && (per_q == PW'(DATA_END - 2));

endmodule

// File: rtl/adc_sample_shift.sv
module adc_sample_shift #(
    parameter int DATA_BITS = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic                        last_bit,
    input  logic                        bit_in,
    output logic signed [DATA_BITS-1:0] sample,
    output logic                        sample_valid
);
    logic [DATA_BITS-1:0] sr_q;
    logic [DATA_BITS-1:0] sr_next;

    assign sr_next = {sr_q[DATA_BITS-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q         <= '0;
            sample       <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            if (shift_en) sr_q <= sr_next;
            if (last_bit) begin
                sample       <= sr_next;
                sample_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_CLKS  = 384,
    parameter int MARKER_CLKS = 36,
    parameter int LOW_AT      = 12,
    parameter int HIGH_AT     = 15,
    parameter int DATA_BITS   = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adc_dout,
    output logic                        adc_clk,
    output logic                        adc_sclk,
    output logic signed [DATA_BITS-1:0] sample,
    output logic                        sample_valid,
    output logic                        sync_err
);
    logic tick;
    logic din_s;
    logic shift_en;
    logic last_bit;

    adc_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk         (clk),
        .rst_n       (rst_n),
        .adc_clk     (adc_clk),
        .period_tick (tick)
    );

    adc_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_dout),
        .q     (din_s)
    );

    adc_frame_fsm #(
        .FRAME_CLKS  (FRAME_CLKS),
        .MARKER_CLKS (MARKER_CLKS),
        .LOW_AT      (LOW_AT),
        .HIGH_AT     (HIGH_AT),
        .DATA_BITS   (DATA_BITS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .din      (din_s),
        .sclk     (adc_sclk),
        .shift_en (shift_en),
        .last_bit (last_bit),
        .sync_err (sync_err)
    );

    adc_sample_shift #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift_en     (shift_en),
        .last_bit     (last_bit),
        .bit_in       (din_s),
        .sample       (sample),
        .sample_valid (sample_valid)
    );

endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
    parameter int HALF_DIV  = 2,
    parameter int DATA_BITS = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 adc_clk,
    input logic                 adc_sclk,
    input logic [DATA_BITS-1:0] sample,
    input logic                 sample_valid,
    input logic                 sync_err
);
    logic        clk_d;
    logic        sclk_d;
    logic        seen;
    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d  <= 1'b0;
            sclk_d <= 1'b0;
            seen   <= 1'b0;
            run    <= '0;
        end else begin
            clk_d  <= adc_clk;
            sclk_d <= adc_sclk;
            if (adc_clk != clk_d) begin
                seen <= 1'b1;
                run  <= 16'd1;
            end else if (run != 16'hFFFF) begin
                run <= run + 1'b1;
            end
        end
    end

    // R1
    clk_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && adc_clk != clk_d) |-> run == 16'(HALF_DIV));

    // R1
    clk_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> run <= 16'(HALF_DIV));

    // R4
    sclk_on_clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sclk != sclk_d) |-> (adc_clk && !clk_d));

    // R4
    sclk_one_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_d && adc_clk && !clk_d) |-> !adc_sclk);

    // R3
    err_no_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> !adc_sclk);

    // R6
    valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R6
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(sample));

endmodule

bind adc_frame_reader adc_frame_reader_chk #(
    .HALF_DIV  (HALF_DIV),
    .DATA_BITS (DATA_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .adc_clk      (adc_clk),
    .adc_sclk     (adc_sclk),
    .sample       (sample),
    .sample_valid (sample_valid),
    .sync_err     (sync_err)
);

// File: tb/adc_frame_reader_test.sv
module adc_frame_reader_test;
    localparam int HALF = 2;
    localparam int NV   = 7;
    localparam logic [23:0] VW [NV] = '{24'hA5A5A5, 24'h000000, 24'hFFFFFF,
                                        24'h800000, 24'h7FFFFF, 24'h000001,
                                        24'h5A5A5A};
    localparam int VE [NV] = '{-5921371, 0, -1, -8388608, 8388607, 1, 5921370};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dout = 1'b1;
    logic adc_clk, adc_sclk, sample_valid, sync_err;
    logic signed [23:0] sample;

    always #5 clk = ~clk;

    adc_frame_reader #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .adc_dout(dout), .adc_clk(adc_clk),
        .adc_sclk(adc_sclk), .sample(sample), .sample_valid(sample_valid),
        .sync_err(sync_err)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int vcnt = 0, ecnt = 0, srise = 0, bad_runs = 0, clk_edges = 0, run = 0;
    logic sclk_p = 1'b0, clk_p = 1'b0;
    logic signed [23:0] got = '0;

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_valid) begin
                vcnt++;
                got = sample;
            end
            if (sync_err) ecnt++;
            if (adc_sclk && !sclk_p) srise++;
            sclk_p = adc_sclk;
            if (adc_clk != clk_p) begin
                if (clk_edges > 0 && run != HALF) bad_runs++;
                clk_edges++;
                run = 1;
            end else begin
                run++;
            end
            clk_p = adc_clk;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // kind 0: good marker; 1: never goes low; 2: never returns high
    function automatic logic level(input int kind, input int p, input logic [23:0] w);
        if (p < 36) begin
            case (kind)
                0:       return !(p >= 12 && p < 15);
                1:       return 1'b1;
                default: return p < 12;
            endcase
        end else if (p < 84) begin
            return w[23 - (p - 36) / 2];
        end
        return 1'b0;
    endfunction

    task automatic send_frame(input int kind, input logic [23:0] w);
        for (int p = 0; p < 384; p++) begin
            @(posedge adc_clk);
            #1 dout = level(kind, p, w);
        end
    endtask

    task automatic run_frame(input string tag, input int kind, input logic [23:0] w,
                             input int exp_v, input int exp_s, input int exp_e,
                             input int exp_r);
        int v0, e0, r0;
        v0 = vcnt; e0 = ecnt; r0 = srise;
        send_frame(kind, w);
        chk({tag, " R6 valid strobes"}, vcnt - v0, exp_v);
        chk({tag, " R3 sync errors"}, ecnt - e0, exp_e);
        chk({tag, " R4 sclk pulses"}, srise - r0, exp_r);
        if (exp_v == 1) chk({tag, " R5 word"}, int'(got), exp_s);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 adc_clk", int'(adc_clk), 0);
        chk("R9 adc_sclk", int'(adc_sclk), 0);
        chk("R9 valid", int'(sample_valid), 0);
        chk("R9 err", int'(sync_err), 0);
        chk("R9 sample", int'(sample), 0);
        rst_n = 1'b1;

        // R2: line high at reset release, then low: no frame start
        repeat (10) @(posedge adc_clk);
        #1 dout = 1'b0;
        repeat (6) @(posedge adc_clk);
        chk("R2 no valid while hunting", vcnt, 0);
        chk("R2 no error while hunting", ecnt, 0);
        chk("R2 no sclk while hunting", srise, 0);

        // table of back-to-back frames (R7)
        for (int i = 0; i < NV; i++) begin
            run_frame($sformatf("R7 vec%0d", i), 0, VW[i], 1, VE[i], 0, 25);
        end

        // corner cases: bad markers and recovery
        run_frame("R3 no-low marker", 1, 24'h0, 0, 0, 1, 0);
        run_frame("R8 recover after no-low", 0, 24'hC00003, 1, -4194301, 0, 25);
        run_frame("R3 no-high marker", 2, 24'h0, 0, 0, 1, 0);
        run_frame("R8 recover after no-high", 0, 24'h123456, 1, 1193046, 0, 25);

        // R1 continuous master clock
        chk("R1 half-period violations", bad_runs, 0);
        chk("R1 clock kept toggling", int'(clk_edges > 2 * 384 * 11), 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule